// File: doc/BRIEF.md
# Debounced Wake-up Input Controller

This block watches ten external wake-up pins and raises a wake-up request for the core supply when one of them shows a qualified event. Each pin has its own enable bit and its own polarity bit. A qualified event is an edge towards the selected active level, followed by that level held for a debounce interval. A shared 4-bit code sets the interval. Each pin passes through a two-flop synchronizer. An edge detector and a restartable hold counter then qualify the pin.

Software programs the enables and polarities through one 32-bit read/write configuration word on a simple register port. An external write-lock input blocks every write to that word. Qualified events set sticky bits in a per-pin source vector. The wake-up request is the OR of that vector. It stays asserted until a clear strobe arrives.

Top module: `wakein_ctrl`

## Requirements
- R1: After a synchronous reset the configuration word reads 0, so all pins are disabled and low-active. `wake_req` is 0 and `wake_src` is 0.
- R2: The configuration word sits at register offset 0x0C. Bit i (0..9) enables pin i, and bit 16+i selects its active level (1 = rising edge then high, 0 = falling edge then low). Reads return the stored word. Reads at other offsets return 0, and writes to other offsets change nothing.
- R3: Bits 10..15 and 26..31 of the configuration word always read as 0, whatever value was written to them.
- R4: While `wp_lock` is 1, a write to the configuration word leaves it unchanged.
- R5: A pin whose enable bit is 0 never sets its `wake_src` bit, whatever it does.
- R6: With N = 2^`dbc_code`, a high-active pin that is high at N+1 consecutive rising clock edges, after being low, sets its `wake_src` bit and `wake_req`. Both are visible after the (N+3)th of those edges. A high level seen at only N edges sets nothing.
- R7: A low-active pin qualifies on a falling edge followed by a low level, with the same timing as R6. A rising edge followed by a high level does nothing on such a pin.
- R8: A level that is already active when a pin becomes enabled is not an event. Only a new edge towards the active level can start one.
- R9: If the level leaves the active state before the count completes, the count is dropped. The next edge starts a full new interval.
- R10: `wake_src` bits are sticky and `wake_req` is their OR. `wake_clear` clears every bit at the next clock edge. An event that qualifies in the same cycle as a clear is kept.
- R11: A write that changes a pin's enable or polarity bit aborts any count in progress on that pin.
- R12: `dbc_code` selects the hold length N = 2^code. It is checked at code 0 (N = 1), code 2 (N = 4) and code 5 (N = 32).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wen | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for the current `bus_addr` |
| wp_lock | input | 1 | Write-lock: 1 blocks configuration writes |
| dbc_code | input | 4 | Debounce code, hold length 2^code cycles |
| wake_pins | input | 10 | Asynchronous wake-up pins |
| wake_clear | input | 1 | Clears all sticky source bits |
| wake_req | output | 1 | Wake-up request for the core supply |
| wake_src | output | 10 | Per-pin sticky record of qualified events |

## Verification
The high-active pins are tried with four patterns: a pulse one edge too short, a pulse of exactly the minimum length, a pulse with a one-cycle drop in the middle, and two pins firing together. Between them these separate an off-by-one in the counter, a counter that keeps its count across a drop, and wrong per-pin attribution. A low-active pin gets a rising-then-high pattern that must be ignored and a falling-then-low pattern that must fire, which shows whether the polarity is applied. Other tests check that a level already active at enable time does not fire, that a clear in the same cycle as a new event keeps the event, and that the minimum and too-short lengths at codes 0 and 5 confirm the 2^code scaling.

// File: rtl/wakein_pkg.sv
package wakein_pkg;

    localparam int PIN_N    = 10;
    localparam int EN_LSB   = 0;
    localparam int TYPE_LSB = 16;
    localparam int WORD_W   = 32;
    localparam int CODE_W   = 4;
    localparam int CNT_W    = (1 << CODE_W);

    typedef enum logic {
        LVL_LOW  = 1'b0,
        LVL_HIGH = 1'b1
    } lvl_e;

    typedef struct packed {
        logic [PIN_N-1:0] pol;
        logic [PIN_N-1:0] en;
    } cfg_t;

    function automatic logic [WORD_W-1:0] cfg_to_word(input cfg_t c);
        logic [WORD_W-1:0] w;
        w = '0;
        w[TYPE_LSB +: PIN_N] = c.pol;
        w[EN_LSB   +: PIN_N] = c.en;
        return w;
    endfunction

    function automatic cfg_t word_to_cfg(input logic [PIN_N-1:0] en_bits,
                                         input logic [PIN_N-1:0] pol_bits);
        cfg_t c;
        c.en  = en_bits;
        c.pol = pol_bits;
        return c;
    endfunction

    function automatic logic [CNT_W-1:0] hold_len(input logic [CODE_W-1:0] code);
        return CNT_W'(1) << code;
    endfunction

endpackage

// File: rtl/wakein_cfg_reg.sv
module wakein_cfg_reg
    import wakein_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int REG_OFS = 12
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   bus_wen,
    input  logic [ADDR_W-1:0]      bus_addr,
    input  logic [WORD_W-1:0]      bus_wdata,
    input  logic                   wp_lock,
    output logic [WORD_W-1:0]      bus_rdata,
    output cfg_t                   cfg,
    output logic [PIN_N-1:0]       cfg_chg
);

    logic  hit;
    logic  wr_ok;
    cfg_t  cfg_nxt;
    logic  unused_rsvd;

    assign hit     = (bus_addr == ADDR_W'(REG_OFS));
    assign wr_ok   = bus_wen && hit && !wp_lock;
    assign cfg_nxt = word_to_cfg(bus_wdata[EN_LSB +: PIN_N], bus_wdata[TYPE_LSB +: PIN_N]);
    assign unused_rsvd = ^{bus_wdata[WORD_W-1:TYPE_LSB+PIN_N], bus_wdata[TYPE_LSB-1:EN_LSB+PIN_N]};

    always_comb begin
        cfg_chg = '0;
        if (wr_ok) begin
            cfg_chg = (cfg_nxt.en ^ cfg.en) | (cfg_nxt.pol ^ cfg.pol);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= '0;
        end else if (wr_ok) begin
            cfg <= cfg_nxt;
        end
    end

    assign bus_rdata = hit ? cfg_to_word(cfg) : '0;

    assert_lock_blocks_R4: assert property (@(posedge clk) disable iff (rst)
        (bus_wen && wp_lock) |=> $stable(cfg));

    assert_other_ofs_R2: assert property (@(posedge clk) disable iff (rst)
        (bus_wen && !hit) |=> $stable(cfg));

endmodule

// File: rtl/wakein_sync.sv
module wakein_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_async,
    output logic [W-1:0] d_sync
);

    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            d_sync <= '0;
        end else begin
            stage1 <= d_async;
            d_sync <= stage1;
        end
    end

endmodule

// File: rtl/wakein_qual.sv
module wakein_qual
    import wakein_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              lvl,
    input  logic              en,
    input  lvl_e              pol,
    input  logic              chg,
    input  logic [CODE_W-1:0] code,
    output logic              fire
);

    logic             prev;
    logic             act;
    logic             act_prev;
    logic             edge_hit;
    logic             armed;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] len;

    assign act      = (pol == LVL_HIGH) ? lvl  : ~lvl;
    assign act_prev = (pol == LVL_HIGH) ? prev : ~prev;
    assign edge_hit = act && !act_prev;
    assign len      = hold_len(code);
    assign fire     = en && !chg && armed && act && (cnt >= len);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev <= 1'b0;
        end else begin
            prev <= lvl;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !en || chg) begin
            armed <= 1'b0;
            cnt   <= '0;
        end else if (armed) begin
            if (!act || (cnt >= len)) begin
                armed <= 1'b0;
                cnt   <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end else if (edge_hit) begin
            armed <= 1'b1;
            cnt   <= CNT_W'(1);
        end
    end

    assert_level_held_R6: assert property (@(posedge clk) disable iff (rst)
        fire |-> $past(act));

    assert_new_edge_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(armed) |-> $past(edge_hit));

    assert_drop_restarts_R9: assert property (@(posedge clk) disable iff (rst)
        (armed && !act) |=> !armed);

    assert_reconfig_abort_R11: assert property (@(posedge clk) disable iff (rst)
        chg |=> !armed);

    assert_disabled_idle_R5: assert property (@(posedge clk) disable iff (rst)
        !en |=> !armed);

endmodule

// File: rtl/wakein_ctrl.sv
module wakein_ctrl
    import wakein_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int REG_OFS = 12
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_wen,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [WORD_W-1:0]   bus_wdata,
    output logic [WORD_W-1:0]   bus_rdata,
    input  logic                wp_lock,
    input  logic [CODE_W-1:0]   dbc_code,
    input  logic [PIN_N-1:0]    wake_pins,
    input  logic                wake_clear,
    output logic                wake_req,
    output logic [PIN_N-1:0]    wake_src
);

    cfg_t             cfg;
    logic [PIN_N-1:0] cfg_chg;
    logic [PIN_N-1:0] pins_s;
    logic [PIN_N-1:0] fire;

    wakein_cfg_reg #(
        .ADDR_W  (ADDR_W),
        .REG_OFS (REG_OFS)
    ) u_cfg (
        .clk       (clk),
        .rst       (rst),
        .bus_wen   (bus_wen),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .wp_lock   (wp_lock),
        .bus_rdata (bus_rdata),
        .cfg       (cfg),
        .cfg_chg   (cfg_chg)
    );

    wakein_sync #(
        .W (PIN_N)
    ) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async (wake_pins),
        .d_sync  (pins_s)
    );

    for (genvar i = 0; i < PIN_N; i++) begin : g_pin
        wakein_qual u_qual (
            .clk  (clk),
            .rst  (rst),
            .lvl  (pins_s[i]),
            .en   (cfg.en[i]),
            .pol  (lvl_e'(cfg.pol[i])),
            .chg  (cfg_chg[i]),
            .code (dbc_code),
            .fire (fire[i])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wake_src <= '0;
        end else begin
            wake_src <= (wake_clear ? '0 : wake_src) | fire;
        end
    end

    assign wake_req = |wake_src;

    assert_src_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        !wake_clear |=> ((wake_src & $past(wake_src)) == $past(wake_src)));

    assert_clear_empties_R10: assert property (@(posedge clk) disable iff (rst)
        (wake_clear && (fire == '0)) |=> !wake_req);

    assert_event_recorded_R6: assert property (@(posedge clk) disable iff (rst)
        (fire != '0) |=> wake_req);

endmodule

// File: tb/test_wakein_ctrl.sv
`timescale 1ns/1ps
module test_wakein_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wen = 1'b0;
    logic [7:0]  bus_addr = 8'h0C;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        wp_lock = 1'b0;
    logic [3:0]  dbc_code = 4'd2;
    logic [9:0]  wake_pins = '0;
    logic        wake_clear = 1'b0;
    logic        wake_req;
    logic [9:0]  wake_src;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    typedef struct {
        string       tag;
        logic [9:0]  src;
        logic        req;
        logic [31:0] rd;
        bit          use_rd;
    } exp_t;

    exp_t sb_q[$];

    always #10 clk = ~clk;

    wakein_ctrl i_wakein_ctrl (
        .clk        (clk),
        .rst        (rst),
        .bus_wen    (bus_wen),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .wp_lock    (wp_lock),
        .dbc_code   (dbc_code),
        .wake_pins  (wake_pins),
        .wake_clear (wake_clear),
        .wake_req   (wake_req),
        .wake_src   (wake_src)
    );

    // monitor: pops expected items and compares away from the active edge
    always @(negedge clk) begin
        while (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            n_run++;
            if (wake_src !== e.src || wake_req !== e.req) begin
                n_fail++;
                $display("FAIL %s: src=%h req=%b expected src=%h req=%b",
                         e.tag, wake_src, wake_req, e.src, e.req);
            end else if (e.use_rd && bus_rdata !== e.rd) begin
                n_fail++;
                $display("FAIL %s: rdata=%h expected %h", e.tag, bus_rdata, e.rd);
            end
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic push(input string tag, input logic [9:0] s, input logic r,
                        input logic [31:0] rd, input bit use_rd);
        exp_t e;
        e.tag = tag; e.src = s; e.req = r; e.rd = rd; e.use_rd = use_rd;
        sb_q.push_back(e);
        step(1);
    endtask

    task automatic expect_out(input string tag, input logic [9:0] s);
        exp_t e;
        e.tag = tag; e.src = s; e.req = |s; e.rd = '0; e.use_rd = 0;
        sb_q.push_back(e);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wen   = 1'b1;
        step(1);
        bus_wen   = 1'b0;
        bus_addr  = 8'h0C;
    endtask

    task automatic clr();
        wake_clear = 1'b1;
        step(1);
        wake_clear = 1'b0;
    endtask

    localparam logic [31:0] CFG_MAIN = 32'h0213_021B;

    initial begin
        step(3);
        rst = 1'b0;
        step(1);
        push("R1 reset state", 10'h000, 1'b0, 32'h0, 1);

        // R2 and R3: write with reserved bits set
        wr(8'h0C, 32'hFE13_FE1B);
        push("R2 R3 readback", 10'h000, 1'b0, CFG_MAIN, 1);
        bus_addr = 8'h08;
        #1;
        push("R2 other offset reads zero", 10'h000, 1'b0, 32'h0, 1);
        bus_addr = 8'h0C;
        wr(8'h10, 32'hFFFF_FFFF);
        push("R2 write elsewhere ignored", 10'h000, 1'b0, CFG_MAIN, 1);

        // R4
        wp_lock = 1'b1;
        wr(8'h0C, 32'h0);
        wp_lock = 1'b0;
        push("R4 locked write ignored", 10'h000, 1'b0, CFG_MAIN, 1);

        // R5: pin 2 disabled
        wake_pins[2] = 1'b1;
        step(10);
        wake_pins[2] = 1'b0;
        step(4);
        expect_out("R5 disabled pin", 10'h000);
        step(1);

        // R6: too short then exact minimum (N=4)
        wake_pins[0] = 1'b1;
        step(4);
        wake_pins[0] = 1'b0;
        step(5);
        expect_out("R6 short pulse", 10'h000);
        step(1);
        wake_pins[0] = 1'b1;
        step(5);
        wake_pins[0] = 1'b0;
        step(1);
        expect_out("R6 one edge early", 10'h000);
        step(1);
        expect_out("R6 minimum pulse fires", 10'h001);
        step(1);
        clr();
        expect_out("R10 clear", 10'h000);
        step(1);

        // R7: pin 3 low-active
        wake_pins[3] = 1'b1;
        step(10);
        expect_out("R7 rising ignored", 10'h000);
        step(1);
        wake_pins[3] = 1'b0;
        step(5);
        step(1);
        expect_out("R7 one edge early", 10'h000);
        step(1);
        expect_out("R7 falling then low fires", 10'h008);
        step(1);
        clr();

        // R8: pin 1 already high when enabled
        wr(8'h0C, CFG_MAIN & ~32'h0000_0002);
        wake_pins[1] = 1'b1;
        step(4);
        wr(8'h0C, CFG_MAIN);
        step(20);
        expect_out("R8 level at enable ignored", 10'h000);
        step(1);
        wake_pins[1] = 1'b0;
        step(4);

        // R9: drop restarts the interval (pin 4)
        wake_pins[4] = 1'b1;
        step(4);
        wake_pins[4] = 1'b0;
        step(1);
        wake_pins[4] = 1'b1;
        step(5);
        wake_pins[4] = 1'b0;
        step(1);
        expect_out("R9 restarted count not done", 10'h000);
        step(1);
        expect_out("R9 restarted count fires", 10'h010);
        step(1);

        // R10: clear in the same cycle as a new event on pin 9
        wake_pins[9] = 1'b1;
        step(5);
        wake_pins[9] = 1'b0;
        step(1);
        wake_clear = 1'b1;
        step(1);
        wake_clear = 1'b0;
        expect_out("R10 event kept over clear", 10'h200);
        step(1);
        clr();

        // R11: reconfiguration during a count (pin 0)
        wake_pins[0] = 1'b1;
        step(3);
        wr(8'h0C, CFG_MAIN & ~32'h0001_0000);
        wr(8'h0C, CFG_MAIN);
        step(20);
        expect_out("R11 reconfig aborts count", 10'h000);
        step(1);
        wake_pins[0] = 1'b0;
        step(4);

        // R10: two pins together
        wake_pins[0] = 1'b1;
        wake_pins[9] = 1'b1;
        step(5);
        wake_pins[0] = 1'b0;
        wake_pins[9] = 1'b0;
        step(2);
        expect_out("R10 two sources", 10'h201);
        step(1);
        clr();

        // R12: code 0 (N=1)
        dbc_code = 4'd0;
        wake_pins[0] = 1'b1;
        step(1);
        wake_pins[0] = 1'b0;
        step(5);
        expect_out("R12 code0 short", 10'h000);
        step(1);
        wake_pins[0] = 1'b1;
        step(2);
        wake_pins[0] = 1'b0;
        step(1);
        expect_out("R12 code0 early", 10'h000);
        step(1);
        expect_out("R12 code0 fires", 10'h001);
        step(1);
        clr();

        // R12: code 5 (N=32)
        dbc_code = 4'd5;
        wake_pins[0] = 1'b1;
        step(32);
        wake_pins[0] = 1'b0;
        step(5);
        expect_out("R12 code5 short", 10'h000);
        step(1);
        wake_pins[0] = 1'b1;
        step(33);
        wake_pins[0] = 1'b0;
        step(1);
        expect_out("R12 code5 early", 10'h000);
        step(1);
        expect_out("R12 code5 fires", 10'h001);
        step(2);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule